// File: doc/BRIEF.md
# Programmable Clock Channel Divider

This block sits after a fast reference clock and turns it into a slower clock, expressed as a one-cycle enable pulse and a squarewave-style level. Both outputs are synchronous to the reference clock. A control word carries a disable flag and an 8-bit divide field. The word is captured only when an update strobe is high. A separate hold input freezes the channel at any time without touching the stored settings. A fixed post-divider, chosen per instance, multiplies the programmed ratio.

The programmable divisor and the fixed divisor are folded into one period length, which drives a single counter. A new divide value never cuts a period short. It waits in a pending register and is loaded when the running period ends, or at once while the channel is stopped. A divide field of zero means the largest divisor, 255, never a divide by zero.

Top module: `chan_div`

## Requirements
- R1: After reset the channel is disabled: `tick_o`, `sq_o` and `active_o` are all low, and the pending divide field is zero.
- R2: The control word is `ctrl_i[7:0]` = divide field N and `ctrl_i[8]` = disable. With disable clear, the period is P = N × FIX_DIV reference cycles. After the enabling update edge, the first `tick_o` comes P−1 cycles later and each later one P cycles after the previous.
- R3: A divide field of 0 gives N = 255.
- R4: With FIX_DIV = 2, every period is twice the FIX_DIV = 1 period for the same field.
- R5: `sq_o` is high for the first floor(P/2) cycles of each P-cycle period. With P = 1 it never rises, and `tick_o` is high on every cycle.
- R6: An update with `ctrl_i[8]` = 1 stops the channel from the next cycle on: `active_o`, `tick_o` and `sq_o` are low.
- R7: While `hold_i` is high, all three outputs are low in that same cycle. After release, the period restarts from its beginning: the first tick comes P−1 cycles after the release.
- R8: A divide field written in the middle of a period does not shorten that period. It takes effect from the next period.
- R9: `active_o` is high exactly while the channel runs. It falls in the same cycle as hold and one cycle after a disabling update.
- R10: Changes on `ctrl_i` while `update_i` is low have no effect on the output period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_i | input | DIV_W+1 | Bit DIV_W = disable, bits DIV_W-1:0 = divide field |
| update_i | input | 1 | Captures `ctrl_i` at the clock edge |
| hold_i | input | 1 | Freezes the channel while high |
| tick_o | output | 1 | One-cycle enable on the last cycle of each period |
| sq_o | output | 1 | Divided squarewave, high in the first half of each period |
| active_o | output | 1 | Channel running |

## Verification
The update strobe acts at the clock edge. The bench numbers the samples taken after that edge from zero and expects the first tick at sample P−1 and the next at 2P−1. Hold acts combinationally on the outputs. The bench therefore samples shortly after driving it, within the same cycle, and counts the restarted period from the release sample. A disabling update is checked one edge later. For a mid-period rewrite, the tick positions are worked out in advance from the old period followed by the new one.

// File: rtl/chan_div.sv
module chan_div #(
  parameter int DIV_W   = 8,
  parameter int FIX_DIV = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W:0]   ctrl_i,
  input  logic             update_i,
  input  logic             hold_i,
  output logic             tick_o,
  output logic             sq_o,
  output logic             active_o
);
  localparam int MAX_PER = ((1 << DIV_W) - 1) * FIX_DIV;
  localparam int PER_W   = $clog2(MAX_PER + 1);

  logic             dis_q;
  logic [DIV_W-1:0] pend_q;
  logic [PER_W-1:0] per_q;
  logic [PER_W-1:0] cnt_q;
  logic             run;
  logic             last;
  logic [DIV_W-1:0] nxt_f;
  logic [DIV_W-1:0] nxt_n;
  logic [PER_W-1:0] nxt_per;

  assign run     = !dis_q && !hold_i;
  assign last    = cnt_q == per_q - PER_W'(1);
  assign nxt_f   = update_i ? ctrl_i[DIV_W-1:0] : pend_q;
  assign nxt_n   = (nxt_f == '0) ? '1 : nxt_f;
  assign nxt_per = PER_W'(nxt_n) * PER_W'(FIX_DIV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q  <= 1'b1;
      pend_q <= '0;
      per_q  <= PER_W'(MAX_PER);
      cnt_q  <= '0;
    end else begin
      if (update_i) begin
        dis_q  <= ctrl_i[DIV_W];
        pend_q <= ctrl_i[DIV_W-1:0];
      end
      if (!run || last) begin
        cnt_q <= '0;
        per_q <= nxt_per;
      end else begin
        cnt_q <= cnt_q + PER_W'(1);
      end
    end
  end

  assign tick_o   = run && last;
  assign sq_o     = run && (cnt_q < (per_q >> 1));
  assign active_o = run;

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_o |-> (!tick_o && !sq_o));

  // R6
  dis_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (update_i && ctrl_i[DIV_W]) |=> !active_o);

  // R7
  hold_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |-> (!active_o && !tick_o && !sq_o));

  // R2
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt_q == '0));

  // R8
  per_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && cnt_q != '0) |-> $stable(per_q));

  // R3
  per_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q != '0) && (per_q <= PER_W'(MAX_PER)));
endmodule

// File: tb/chan_div_tb.sv
module chan_div_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] ctrl_i = '0;
  logic       update_i = 1'b0;
  logic       hold_i = 1'b0;
  logic       tick_o, sq_o, active_o;
  logic       tick2, sq2, act2;
  int         n_chk = 0;
  int         n_bad = 0;

  always #4 clk = ~clk;

  chan_div #(.DIV_W(8), .FIX_DIV(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl_i), .update_i(update_i), .hold_i(hold_i),
    .tick_o(tick_o), .sq_o(sq_o), .active_o(active_o));

  chan_div #(.DIV_W(8), .FIX_DIV(2)) u_dut_fx2 (
    .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl_i), .update_i(update_i), .hold_i(hold_i),
    .tick_o(tick2), .sq_o(sq2), .active_o(act2));

  // field, period with FIX_DIV=1, period with FIX_DIV=2
  localparam int NV = 7;
  localparam int VEC [NV][3] = '{
    '{1, 1, 2}, '{2, 2, 4}, '{3, 3, 6}, '{5, 5, 10},
    '{16, 16, 32}, '{255, 255, 510}, '{0, 255, 510}};

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load(bit dis, int field);
    ctrl_i   = {dis, 8'(field)};
    update_i = 1'b1;
    step();
    update_i = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  initial begin
    int first, ticks, sqs, first2, ticks2, sqs2, t0, t1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 reset outputs", {tick_o, sq_o, active_o, tick2, sq2, act2}, 0);
    load(1'b0, 0);
    load(1'b1, 0);
    // R1: the pending field from reset is zero, so P = 255 when enabled without a new field
    ctrl_i = 9'h000;
    update_i = 1'b0;

    for (int v = 0; v < NV; v++) begin
      load(1'b1, 0);
      load(1'b0, VEC[v][0]);
      // R9
      chk("R9 active after enable", active_o, 1);
      first = -1; ticks = 0; sqs = 0; first2 = -1; ticks2 = 0; sqs2 = 0;
      for (int m = 0; m < 2 * VEC[v][2]; m++) begin
        if (m < 2 * VEC[v][1]) begin
          if (tick_o) begin ticks++; if (first < 0) first = m; end
          if (sq_o && m < VEC[v][1]) sqs++;
        end
        if (tick2) begin ticks2++; if (first2 < 0) first2 = m; end
        if (sq2 && m < VEC[v][2]) sqs2++;
        step();
      end
      // R2 R3
      chk($sformatf("R2/R3 first tick field %0d", VEC[v][0]), first, VEC[v][1] - 1);
      chk($sformatf("R2/R3 tick count field %0d", VEC[v][0]), ticks, 2);
      // R5
      chk($sformatf("R5 sq width field %0d", VEC[v][0]), sqs, VEC[v][1] / 2);
      // R4
      chk($sformatf("R4 fixed first tick field %0d", VEC[v][0]), first2, VEC[v][2] - 1);
      chk($sformatf("R4 fixed tick count field %0d", VEC[v][0]), ticks2, 2);
      chk($sformatf("R4 fixed sq width field %0d", VEC[v][0]), sqs2, VEC[v][2] / 2);
    end

    // R8: period 8 running, rewrite to 3 at sample 2
    load(1'b1, 0);
    load(1'b0, 8);
    t0 = -1; t1 = -1;
    for (int m = 0; m < 14; m++) begin
      if (tick_o) begin if (t0 < 0) t0 = m; else if (t1 < 0) t1 = m; end
      if (m == 2) begin ctrl_i = {1'b0, 8'd3}; update_i = 1'b1; end
      step();
      update_i = 1'b0;
    end
    chk("R8 old period completes", t0, 7);
    chk("R8 new period next", t1, 10);

    // R10: ctrl changes without strobe are ignored
    load(1'b1, 0);
    load(1'b0, 4);
    ctrl_i = {1'b1, 8'd9};
    t0 = -1; t1 = -1;
    for (int m = 0; m < 10; m++) begin
      if (tick_o) begin if (t0 < 0) t0 = m; else if (t1 < 0) t1 = m; end
      step();
    end
    chk("R10 first tick unchanged", t0, 3);
    chk("R10 second tick unchanged", t1, 7);
    chk("R10 still active", active_o, 1);

    // R7: hold, period 4
    load(1'b1, 0);
    load(1'b0, 4);
    step();
    hold_i = 1'b1;
    #1;
    chk("R7 hold gates outputs", {tick_o, sq_o}, 0);
    // R9
    chk("R9 active falls with hold", active_o, 0);
    step();
    step();
    hold_i = 1'b0;
    #1;
    chk("R7 active on release", active_o, 1);
    t0 = -1;
    for (int m = 0; m < 6; m++) begin
      if (tick_o && t0 < 0) t0 = m;
      step();
    end
    chk("R7 restart first tick", t0, 3);

    // R6: disabling update
    load(1'b1, 0);
    chk("R6 disable stops", {active_o, tick_o, sq_o}, 0);
    sqs = 0;
    for (int m = 0; m < 6; m++) begin
      sqs += int'(tick_o) + int'(sq_o);
      step();
    end
    chk("R6 no pulses while disabled", sqs, 0);

    summary();
  end
endmodule